// File: doc/BRIEF.md
# March Test Sequencer for Single-Port SRAM

This block drives a single-port SRAM of 2^AW words, each DW bits wide, through one of six March algorithms and reports whether every read returned the value the algorithm implies. An algorithm is a short list of elements. Each element has an address direction and up to three operations. All operations of an element are applied at one address before the address moves to the next one. Write data is the all-0 or all-1 word. The expected read word is all-0 or all-1 in the same way.

A caller selects the algorithm with a 3-bit code and pulses `start`. The sequencer then owns the memory port and presents one operation per cycle. It checks each read word one cycle after the read is presented, which matches the memory's one-cycle read latency. It keeps a sticky fail flag and records the address and element index of the first mismatch. A single-cycle `done` pulse ends the run. Codes with no algorithm behind them finish at once and raise an error flag.

Top module: `march_bist_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `fail`, `mem_en` and `mem_we` are all 0.
- R2: Codes select these element lists, where up means address 0 to 2^AW-1 and down means the reverse. 0: up(w0); up(r0,w1); up(r1). 1: up(w0); up(r0,w1); down(r1,w0). 2: up(w0); up(r0,w1); down(r1,w0,r0). 3: up(w0); up(r0,w1); down(r1,w0); up(r0). 4: up(w0); up(r0,w1); up(r1,w0); down(r0,w1); down(r1,w0); up(r0). 5: up(w0); up(r0,w1,r1); down(r1,w0,r0); up(r0). Element indices count from 0.
- R3: Within an element, every operation is applied at one address before the address steps by one in the element's direction.
- R4: A run presents exactly 4n, 5n, 6n, 6n, 10n and 8n operations for codes 0 to 5, where n = 2^AW.
- R5: A write presents `mem_en`=1, `mem_we`=1 and `mem_wdata` holding the written bit in all DW bits. A read presents `mem_en`=1 and `mem_we`=0.
- R6: The first operation is presented in the second cycle after the cycle in which `start` is sampled. Operations follow on consecutive cycles with no gaps. `busy` is 1 from the cycle after `start` until `done`.
- R7: The read word on `mem_rdata` in the cycle after a read is presented is compared over all DW bits with the expected word. Any difference sets `fail`.
- R8: `fail`, `fail_addr` and `fail_elem` hold the first mismatch of a run until the next accepted start, which clears `fail`.
- R9: `done` is high for exactly one cycle, two cycles after the cycle that presents the last operation. `busy` is 0 in that cycle and `fail` is already final.
- R10: Codes 6 and 7 raise `done` and `err` in the cycle after `start` and present no operations. `err` stays set until the next start with a valid code.
- R11: `start` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run with the selected algorithm |
| alg_sel | input | 3 | Algorithm code, sampled with start |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Last start carried an unsupported code |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | AW | Address of the first mismatch |
| fail_elem | output | 3 | Element index of the first mismatch |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after the read |

## Verification
The bench builds each algorithm's operation stream from the lists in R2 and compares the memory port with it on every cycle. A wrong element direction, a missing operation or a skipped address therefore shows up at the exact cycle where it occurs. Stuck bits are injected at the most and least significant bit positions and at the first and last addresses. A design that compares only part of the word, samples `mem_rdata` a cycle early or late, or overwrites the first failure with a later one would report a wrong flag, address or element. Further cases pulse `start` in the middle of a run, issue both unsupported codes, and make sure `err` and `fail` clear on the next valid start.

// File: rtl/march_pkg.sv
package march_pkg;
  localparam int ALG_W    = 3;
  localparam int MAX_ELEM = 6;
  localparam int EW       = $clog2(MAX_ELEM);
  localparam int MAX_OPS  = 3;
  localparam int OPW      = $clog2(MAX_OPS + 1);

  // op encoding: bit1 = read, bit0 = data value
  localparam logic [1:0] OP_W0 = 2'b00;
  localparam logic [1:0] OP_W1 = 2'b01;
  localparam logic [1:0] OP_R0 = 2'b10;
  localparam logic [1:0] OP_R1 = 2'b11;

  typedef struct packed {
    logic                         down;
    logic [OPW-1:0]               nops;
    logic [MAX_OPS-1:0][1:0]      ops;
  } elem_t;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FLUSH} seq_state_e;
endpackage

// File: rtl/march_table.sv
module march_table
  import march_pkg::*;
(
  input  logic [ALG_W-1:0] alg,
  input  logic [EW-1:0]    idx,
  output logic             alg_ok,
  output logic [EW-1:0]    nelem,
  output elem_t            elem
);
  localparam logic UP = 1'b0;
  localparam logic DN = 1'b1;

  function automatic elem_t mk(input logic dn, input logic [OPW-1:0] n,
                               input logic [1:0] a, input logic [1:0] b,
                               input logic [1:0] c);
    elem_t e;
    e.down = dn;
    e.nops = n;
    e.ops  = {c, b, a};
    return e;
  endfunction

  always_comb begin
    alg_ok = 1'b1;
    nelem  = '0;
    elem   = mk(UP, OPW'(1), OP_W0, OP_W0, OP_W0);
    case (alg)
      3'd0: begin
        nelem = EW'(3);
        case (idx)
          EW'(1): elem = mk(UP, OPW'(2), OP_R0, OP_W1, OP_W0);
          EW'(2): elem = mk(UP, OPW'(1), OP_R1, OP_W0, OP_W0);
          default: ;
        endcase
      end
      3'd1: begin
        nelem = EW'(3);
        case (idx)
          EW'(1): elem = mk(UP, OPW'(2), OP_R0, OP_W1, OP_W0);
          EW'(2): elem = mk(DN, OPW'(2), OP_R1, OP_W0, OP_W0);
          default: ;
        endcase
      end
      3'd2: begin
        nelem = EW'(3);
        case (idx)
          EW'(1): elem = mk(UP, OPW'(2), OP_R0, OP_W1, OP_W0);
          EW'(2): elem = mk(DN, OPW'(3), OP_R1, OP_W0, OP_R0);
          default: ;
        endcase
      end
      3'd3: begin
        nelem = EW'(4);
        case (idx)
          EW'(1): elem = mk(UP, OPW'(2), OP_R0, OP_W1, OP_W0);
          EW'(2): elem = mk(DN, OPW'(2), OP_R1, OP_W0, OP_W0);
          EW'(3): elem = mk(UP, OPW'(1), OP_R0, OP_W0, OP_W0);
          default: ;
        endcase
      end
      3'd4: begin
        nelem = EW'(6);
        case (idx)
          EW'(1): elem = mk(UP, OPW'(2), OP_R0, OP_W1, OP_W0);
          EW'(2): elem = mk(UP, OPW'(2), OP_R1, OP_W0, OP_W0);
          EW'(3): elem = mk(DN, OPW'(2), OP_R0, OP_W1, OP_W0);
          EW'(4): elem = mk(DN, OPW'(2), OP_R1, OP_W0, OP_W0);
          EW'(5): elem = mk(UP, OPW'(1), OP_R0, OP_W0, OP_W0);
          default: ;
        endcase
      end
      3'd5: begin
        nelem = EW'(4);
        case (idx)
          EW'(1): elem = mk(UP, OPW'(3), OP_R0, OP_W1, OP_R1);
          EW'(2): elem = mk(DN, OPW'(3), OP_R1, OP_W0, OP_R0);
          EW'(3): elem = mk(UP, OPW'(1), OP_R0, OP_W0, OP_W0);
          default: ;
        endcase
      end
      default: alg_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          load_down,
  input  logic          step,
  input  logic          down,
  output logic [AW-1:0] addr,
  output logic          at_end
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (load) addr_q <= load_down ? '1 : '0;
    else if (step) addr_q <= down ? addr_q - 1'b1 : addr_q + 1'b1;
  end

  assign addr   = addr_q;
  assign at_end = down ? (addr_q == '0) : (addr_q == '1);

  // R3
  step_by_one_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (addr_q == ($past(down) ? AW'($past(addr_q) - 1'b1)
                                                : AW'($past(addr_q) + 1'b1))));
endmodule

// File: rtl/march_resp_chk.sv
module march_resp_chk
  import march_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          rd_issued,
  input  logic          rd_bit,
  input  logic [AW-1:0] rd_addr,
  input  logic [EW-1:0] rd_elem,
  input  logic [DW-1:0] rdata,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [EW-1:0] fail_elem
);
  logic          vld_q;
  logic [DW-1:0] exp_q;
  logic [AW-1:0] adr_q;
  logic [EW-1:0] elm_q;
  logic          fail_q;
  logic [AW-1:0] fa_q;
  logic [EW-1:0] fe_q;
  logic          miss;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      exp_q <= '0;
      adr_q <= '0;
      elm_q <= '0;
    end else begin
      vld_q <= rd_issued;
      exp_q <= {DW{rd_bit}};
      adr_q <= rd_addr;
      elm_q <= rd_elem;
    end
  end

  assign miss = vld_q && (rdata != exp_q);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      fail_q <= 1'b0;
      fa_q   <= '0;
      fe_q   <= '0;
    end else if (miss && !fail_q) begin
      fail_q <= 1'b1;
      fa_q   <= adr_q;
      fe_q   <= elm_q;
    end
  end

  assign fail      = fail_q;
  assign fail_addr = fa_q;
  assign fail_elem = fe_q;

  // R8
  fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (fail_q && !clear) |=> (fail_q && $stable(fa_q) && $stable(fe_q)));
  // R7
  fail_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_q) |-> $past(vld_q));
endmodule

// File: rtl/march_bist_ctrl.sv
module march_bist_ctrl
  import march_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    alg_sel,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [2:0]    fail_elem,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  seq_state_e     state_q;
  logic [2:0]     alg_q;
  logic [EW-1:0]  elem_q;
  logic [OPW-1:0] op_q;
  logic           flush_q, done_q, err_q;
  logic           en_q, we_q, bit_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wdata_q;
  logic [EW-1:0]  iss_elem_q;

  elem_t          cur_e, nxt_e, new_e;
  logic [EW-1:0]  cur_n, nxt_n, new_n;
  logic           cur_ok, nxt_ok, new_ok;
  logic [1:0]     op;
  logic           last_op, last_elem, accept, running;
  logic           ag_load, ag_load_down, ag_step, ag_end;
  logic [AW-1:0]  ag_addr;
  logic           cmp_clear;
  logic [EW-1:0]  f_elem;

  march_table u_tbl_cur (.alg(alg_q),   .idx(elem_q),              .alg_ok(cur_ok), .nelem(cur_n), .elem(cur_e));
  march_table u_tbl_nxt (.alg(alg_q),   .idx(EW'(elem_q + 1'b1)), .alg_ok(nxt_ok), .nelem(nxt_n), .elem(nxt_e));
  march_table u_tbl_new (.alg(alg_sel), .idx('0),                  .alg_ok(new_ok), .nelem(new_n), .elem(new_e));

  assign running   = (state_q == S_RUN);
  assign accept    = (state_q == S_IDLE) && start;
  assign op        = cur_e.ops[op_q];
  assign last_op   = (op_q == OPW'(cur_e.nops - 1'b1));
  assign last_elem = (elem_q == EW'(cur_n - 1'b1));

  assign ag_load      = (accept && new_ok) || (running && last_op && ag_end && !last_elem);
  assign ag_load_down = accept ? new_e.down : nxt_e.down;
  assign ag_step      = running && last_op && !ag_end;

  march_addr_gen #(.AW(AW)) u_agen (
    .clk(clk), .rst(rst), .load(ag_load), .load_down(ag_load_down),
    .step(ag_step), .down(cur_e.down), .addr(ag_addr), .at_end(ag_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      alg_q   <= '0;
      elem_q  <= '0;
      op_q    <= '0;
      flush_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          err_q <= !new_ok;
          if (new_ok) begin
            state_q <= S_RUN;
            alg_q   <= alg_sel;
            elem_q  <= '0;
            op_q    <= '0;
          end else begin
            done_q  <= 1'b1;
          end
        end
        S_RUN: begin
          if (!last_op) begin
            op_q <= op_q + 1'b1;
          end else begin
            op_q <= '0;
            if (ag_end) begin
              if (last_elem) begin
                state_q <= S_FLUSH;
                flush_q <= 1'b0;
              end else begin
                elem_q <= elem_q + 1'b1;
              end
            end
          end
        end
        default: begin
          if (flush_q) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
          end else begin
            flush_q <= 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      we_q       <= 1'b0;
      bit_q      <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      iss_elem_q <= '0;
    end else begin
      en_q       <= running;
      we_q       <= running && !op[1];
      bit_q      <= op[0];
      addr_q     <= ag_addr;
      wdata_q    <= (running && !op[1]) ? {DW{op[0]}} : '0;
      iss_elem_q <= elem_q;
    end
  end

  assign cmp_clear = accept;

  march_resp_chk #(.AW(AW), .DW(DW)) u_resp (
    .clk(clk), .rst(rst), .clear(cmp_clear),
    .rd_issued(en_q && !we_q), .rd_bit(bit_q), .rd_addr(addr_q), .rd_elem(iss_elem_q),
    .rdata(mem_rdata), .fail(fail), .fail_addr(fail_addr), .fail_elem(f_elem)
  );

  assign fail_elem = 3'(f_elem);
  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign mem_en    = en_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !en_q);
  // R5
  we_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    we_q |-> en_q);
  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> done_q);
endmodule

// File: tb/test_march_bist_ctrl.sv
module test_march_bist_ctrl;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst, start;
  logic [2:0]    alg_sel;
  logic          busy, done, err, fail;
  logic [AW-1:0] fail_addr;
  logic [2:0]    fail_elem;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  int n_chk = 0, n_bad = 0;
  bit f_en = 0; int f_addr = 0, f_bit = 0; bit f_val = 0;
  logic [DW-1:0] mem [N];
  int q_op[$], q_ad[$], q_el[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  march_bist_ctrl #(.AW(AW), .DW(DW)) i_march_bist_ctrl (
    .clk(clk), .rst(rst), .start(start), .alg_sel(alg_sel), .busy(busy), .done(done),
    .err(err), .fail(fail), .fail_addr(fail_addr), .fail_elem(fail_elem),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // behavioural SRAM with optional stuck bit on one cell
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else begin
        logic [DW-1:0] v;
        v = mem[mem_addr];
        if (f_en && int'(mem_addr) == f_addr) v[f_bit] = f_val;
        mem_rdata <= v;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // op codes here: 0 w0, 1 w1, 2 r0, 3 r1
  task automatic add_elem(input int e, input bit dn, input int n, input int o0, o1, o2);
    int ops[3] = '{o0, o1, o2};
    for (int k = 0; k < N; k++) begin
      int a = dn ? N - 1 - k : k;
      for (int j = 0; j < n; j++) begin
        q_op.push_back(ops[j]); q_ad.push_back(a); q_el.push_back(e);
      end
    end
  endtask

  task automatic build(input int code);
    q_op.delete(); q_ad.delete(); q_el.delete();
    add_elem(0, 0, 1, 0, 0, 0);
    case (code)
      0: begin add_elem(1,0,2,2,1,0); add_elem(2,0,1,3,0,0); end
      1: begin add_elem(1,0,2,2,1,0); add_elem(2,1,2,3,0,0); end
      2: begin add_elem(1,0,2,2,1,0); add_elem(2,1,3,3,0,2); end
      3: begin add_elem(1,0,2,2,1,0); add_elem(2,1,2,3,0,0); add_elem(3,0,1,2,0,0); end
      4: begin add_elem(1,0,2,2,1,0); add_elem(2,0,2,3,0,0); add_elem(3,1,2,2,1,0);
               add_elem(4,1,2,3,0,0); add_elem(5,0,1,2,0,0); end
      default: begin add_elem(1,0,3,2,1,3); add_elem(2,1,3,3,0,2); add_elem(3,0,1,2,0,0); end
    endcase
  endtask

  task automatic run_alg(input int code, input bit fen, input int fa, input int fb,
                         input bit fv, input bit poke);
    int mult[6] = '{4, 5, 6, 6, 10, 8};
    bit x_fail = 0; int x_fa = 0, x_fe = 0; int seen = 0;
    build(code);
    f_en = fen; f_addr = fa; f_bit = fb; f_val = fv;
    for (int i = 0; i < q_op.size(); i++)
      if (!x_fail && q_op[i] >= 2 && fen && q_ad[i] == fa && (q_op[i] & 1) != int'(fv)) begin
        x_fail = 1; x_fa = q_ad[i]; x_fe = q_el[i];
      end
    @(negedge clk); start = 1; alg_sel = 3'(code);
    @(negedge clk); start = 0;
    chk(busy && !mem_en && !done, "R6 start", {busy, mem_en, done}, 3'b100);
    for (int i = 0; i < q_op.size(); i++) begin
      longint act, expv;
      @(negedge clk);
      start = poke && (i == 5);
      if (start) alg_sel = 3'd0;
      act  = {mem_en, mem_we, mem_addr, mem_we ? mem_wdata : {DW{1'b0}}};
      expv = {1'b1, q_op[i] < 2, AW'(q_ad[i]), q_op[i] < 2 ? {DW{q_op[i][0]}} : {DW{1'b0}}};
      chk(act == expv, $sformatf("R2 R3 R5 alg %0d op %0d", code, i), act, expv);
      if (mem_en) seen++;
    end
    start = 0;
    @(negedge clk);
    chk(!mem_en && !done, "R9 drain", {mem_en, done}, 0);
    @(negedge clk);
    chk(done && !busy, "R9 done", {done, busy}, 2'b10);
    chk(seen == mult[code] * N, "R4 op count", seen, mult[code] * N);
    chk(fail == x_fail, "R7 fail flag", fail, x_fail);
    if (x_fail) begin
      chk(int'(fail_addr) == x_fa, "R8 fail_addr", fail_addr, x_fa);
      chk(int'(fail_elem) == x_fe, "R8 fail_elem", fail_elem, x_fe);
    end
    @(negedge clk);
    chk(!done && fail == x_fail, "R9 R8 after done", {done, fail}, {1'b0, x_fail});
  endtask

  task automatic run_bad(input int code);
    @(negedge clk); start = 1; alg_sel = 3'(code);
    @(negedge clk); start = 0;
    chk(done && err && !busy && !mem_en && !fail, "R10 immediate", {done, err, busy, mem_en, fail}, 5'b11000);
    @(negedge clk);
    chk(!done && err && !mem_en, "R10 hold", {done, err, mem_en}, 3'b010);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1; start = 0; alg_sel = 0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk({busy, done, err, fail, mem_en, mem_we} == 0, "R1 reset", {busy, done, err, fail, mem_en, mem_we}, 0);
    run_alg(1, 0, 0, 0, 0, 1);          // R11 start pulse mid-run
    run_alg(0, 1, 5, 7, 1, 0);          // MSB stuck at 1
    run_alg(2, 1, 0, 0, 0, 0);          // LSB stuck at 0, first address
    run_alg(3, 0, 0, 0, 0, 0);
    run_alg(4, 1, N - 1, 3, 0, 0);      // last address
    run_bad(6);                          // R10, also clears fail
    run_bad(7);
    run_alg(5, 1, 9, 6, 1, 0);
    chk(!err, "R10 err cleared", err, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule